// File: doc/BRIEF.md
# SMBus Host Controller Register Bank

This block is the byte-wide register file that sits between a host processor bus and an SMBus transaction engine. Software sets up a transfer by writing a command byte, a target address with its direction bit, up to two data bytes or a 32-entry block buffer, and a control byte. When the control byte has its start bit set, the bank raises a busy flag and gives the engine a one-cycle start pulse. The engine reports back through completion and error flags, returned data bytes and a side port into the block buffer. Software then polls or takes the interrupt, reads the results and clears the status flags by writing ones to them.

The block buffer is reached through one data offset and an internal pointer. Each access to that offset moves the pointer forward by one and wraps it after the last entry. Writing the status register or reading the control register sets the pointer back to zero. Reads have no wait state: read data is valid in the same cycle as the access, and the side effects take place at the clock edge that closes it.

Top module: `smbh_regbank`

## Requirements
- R1: Host offsets decode as status 0x0, control 0x2, command 0x3, target address 0x4, data-low 0x5, data-high 0x6, block data 0x7. Any other offset, including 0x1 and 0x8 to 0xF, reads as 0x00, and writes to it change nothing.
- R2: Status bits are: bit0 busy, bit1 interrupt, bit2 device error, bit3 bus error, bit4 failed, bit5 alert, bit6 in-use, bit7 byte done.
- R3: A host write to status clears each status bit whose written bit is 1. Bits written as 0 keep their value.
- R4: Every host write to status sets the block pointer to 0, whatever data is written.
- R5: A host write to control stores all 8 bits. If written bit 6 is 1, the busy status bit is 1 from the next cycle and eng_start is high for exactly that one cycle.
- R6: A host read of control returns the stored bits [4:0] with bits [7:5] as 0, and it sets the block pointer to 0.
- R7: Each host read or write at block data accesses the entry at the pointer, and the pointer then advances by one. After entry 31 it wraps to entry 0.
- R8: eng_proto carries control bits [4:2]. eng_dir_rd carries target-address bit 0, and eng_slave carries target-address bits [7:1].
- R9: eng_done sets byte done and interrupt. eng_dev_err, eng_bus_err and eng_failed each set their own bit. Any of these four clears busy. When a host clear of the same bit falls in the same cycle, the set wins.
- R10: irq is high exactly while the interrupt status bit is 1.
- R11: eng_ld0 and eng_ld1 load eng_ret0 and eng_ret1 into data-low and data-high, and they win over a host write in the same cycle. eng_blk_we writes buffer entry eng_blk_idx. eng_blk_rdata always shows the entry at eng_blk_idx.
- R12: Synchronous reset sets every register, the pointer and every buffer entry to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Host access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data, same cycle as the access, 0 when idle |
| irq | output | 1 | Interrupt level |
| eng_start | output | 1 | One-cycle start request to the engine |
| eng_proto | output | 3 | Protocol select |
| eng_slave | output | 7 | 7-bit target address |
| eng_dir_rd | output | 1 | Transfer direction, 1 = read |
| eng_cmd | output | 8 | Command byte |
| eng_wd0 | output | 8 | Data-low register |
| eng_wd1 | output | 8 | Data-high register |
| eng_done | input | 1 | Completion pulse |
| eng_dev_err | input | 1 | Device error pulse |
| eng_bus_err | input | 1 | Bus error pulse |
| eng_failed | input | 1 | Failed pulse |
| eng_ld0 | input | 1 | Load eng_ret0 into data-low |
| eng_ld1 | input | 1 | Load eng_ret1 into data-high |
| eng_ret0 | input | 8 | Returned low byte |
| eng_ret1 | input | 8 | Returned high byte |
| eng_blk_we | input | 1 | Engine write to the block buffer |
| eng_blk_idx | input | PTR_W | Engine buffer index |
| eng_blk_wdata | input | 8 | Engine buffer write data |
| eng_blk_rdata | output | 8 | Buffer entry at eng_blk_idx |

## Verification
The assertions check a set of rules on every cycle. The write-one-to-clear rule, including bits written as 0, is checked whenever no engine flag arrives in the same cycle. They also check that the pointer returns to zero after a status write or a control read, that each block access moves the pointer by one with the wrap, that a start write is followed by busy and a single start pulse, that control reads mask the upper bits, that unmapped reads return zero, and that engine flags set their bits. Only the bench scenarios can show the stored contents. These include buffer data written at one pointer value and read back after a pointer reset, the overwrite of entry 0 after 33 writes, the priority of a set over a clear in the same cycle, the engine's loads of returned data, and the clearing of every register and buffer entry by a mid-run reset.

// File: rtl/smbh_pkg.sv
package smbh_pkg;

    localparam logic [7:0] OFF_STS = 8'h00;
    localparam logic [7:0] OFF_CTL = 8'h02;
    localparam logic [7:0] OFF_CMD = 8'h03;
    localparam logic [7:0] OFF_ADR = 8'h04;
    localparam logic [7:0] OFF_D0  = 8'h05;
    localparam logic [7:0] OFF_D1  = 8'h06;
    localparam logic [7:0] OFF_BLK = 8'h07;

    localparam int SB_BUSY   = 0;
    localparam int SB_INTR   = 1;
    localparam int SB_DEVERR = 2;
    localparam int SB_BUSERR = 3;
    localparam int SB_FAIL   = 4;
    localparam int SB_DONE   = 7;

    localparam int         CTL_GO_BIT  = 6;
    localparam logic [7:0] CTL_RD_MASK = 8'h1F;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_STS,
        REG_CTL,
        REG_CMD,
        REG_ADR,
        REG_D0,
        REG_D1,
        REG_BLK
    } smbh_reg_e;

    typedef struct packed {
        logic done;
        logic dev_err;
        logic bus_err;
        logic failed;
    } smbh_evt_t;

    function automatic smbh_reg_e smbh_lookup(input logic [7:0] off);
        case (off)
            OFF_STS: return REG_STS;
            OFF_CTL: return REG_CTL;
            OFF_CMD: return REG_CMD;
            OFF_ADR: return REG_ADR;
            OFF_D0:  return REG_D0;
            OFF_D1:  return REG_D1;
            OFF_BLK: return REG_BLK;
            default: return REG_NONE;
        endcase
    endfunction

    function automatic logic [7:0] smbh_set_mask(input smbh_evt_t e, input logic go);
        logic [7:0] m;
        m = 8'h00;
        m[SB_DONE]   = e.done;
        m[SB_INTR]   = e.done;
        m[SB_DEVERR] = e.dev_err;
        m[SB_BUSERR] = e.bus_err;
        m[SB_FAIL]   = e.failed;
        m[SB_BUSY]   = go;
        return m;
    endfunction

endpackage

// File: rtl/smbh_decode.sv
module smbh_decode
    import smbh_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] bus_addr,
    output smbh_reg_e         reg_sel
);
    logic [7:0] off;

    generate
        if (ADDR_W > 8) begin : g_wide
            assign off = (|bus_addr[ADDR_W-1:8]) ? 8'hFF : bus_addr[7:0];
        end else begin : g_narrow
            assign off = 8'(bus_addr);
        end
    endgenerate

    assign reg_sel = smbh_lookup(off);
endmodule

// File: rtl/smbh_status.sv
module smbh_status
    import smbh_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr_en,
    input  logic [7:0] clr_mask,
    input  logic       go,
    input  smbh_evt_t  evt,
    output logic [7:0] stat
);
    logic [7:0] stat_q;
    logic [7:0] stat_d;

    always_comb begin
        stat_d = stat_q;
        if (clr_en) begin
            stat_d = stat_d & ~clr_mask;
        end
        if (|evt) begin
            stat_d[SB_BUSY] = 1'b0;
        end
        stat_d = stat_d | smbh_set_mask(evt, go);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= 8'h00;
        end else begin
            stat_q <= stat_d;
        end
    end

    assign stat = stat_q;
endmodule

// File: rtl/smbh_blkbuf.sv
module smbh_blkbuf #(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_acc,
    input  logic             host_we,
    input  logic [DW-1:0]    host_wdata,
    input  logic             ptr_clr,
    input  logic             eng_we,
    input  logic [PTR_W-1:0] eng_idx,
    input  logic [DW-1:0]    eng_wdata,
    output logic [DW-1:0]    host_rdata,
    output logic [DW-1:0]    eng_rdata,
    output logic [PTR_W-1:0] ptr
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [DW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] ptr_q;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_entry
            always_ff @(posedge clk) begin
                if (rst) begin
                    mem[i] <= '0;
                end else if (eng_we && eng_idx == PTR_W'(i)) begin
                    mem[i] <= eng_wdata;
                end else if (host_acc && host_we && ptr_q == PTR_W'(i)) begin
                    mem[i] <= host_wdata;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (ptr_clr) begin
            ptr_q <= '0;
        end else if (host_acc) begin
            ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end
    end

    assign host_rdata = mem[ptr_q];
    assign eng_rdata  = mem[eng_idx];
    assign ptr        = ptr_q;
endmodule

// File: rtl/smbh_regbank.sv
module smbh_regbank
    import smbh_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int BLK_DEPTH = 32,
    localparam int PTR_W    = $clog2(BLK_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              irq,
    output logic              eng_start,
    output logic [2:0]        eng_proto,
    output logic [6:0]        eng_slave,
    output logic              eng_dir_rd,
    output logic [7:0]        eng_cmd,
    output logic [7:0]        eng_wd0,
    output logic [7:0]        eng_wd1,
    input  logic              eng_done,
    input  logic              eng_dev_err,
    input  logic              eng_bus_err,
    input  logic              eng_failed,
    input  logic              eng_ld0,
    input  logic              eng_ld1,
    input  logic [7:0]        eng_ret0,
    input  logic [7:0]        eng_ret1,
    input  logic              eng_blk_we,
    input  logic [PTR_W-1:0]  eng_blk_idx,
    input  logic [7:0]        eng_blk_wdata,
    output logic [7:0]        eng_blk_rdata
);
    smbh_reg_e        rsel;
    logic             wr_acc;
    logic             rd_acc;
    logic             go_req;
    logic [7:0]       ctl_q;
    logic [7:0]       cmd_q;
    logic [7:0]       adr_q;
    logic [7:0]       d0_q;
    logic [7:0]       d1_q;
    logic             start_q;
    logic [7:0]       stat_q;
    logic [7:0]       blk_rdata;
    logic [PTR_W-1:0] blk_ptr;
    smbh_evt_t        evt;

    smbh_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_addr (bus_addr),
        .reg_sel  (rsel)
    );

    assign wr_acc = bus_sel && bus_wr;
    assign rd_acc = bus_sel && !bus_wr;
    assign go_req = wr_acc && (rsel == REG_CTL) && bus_wdata[CTL_GO_BIT];

    assign evt = '{done: eng_done, dev_err: eng_dev_err,
                   bus_err: eng_bus_err, failed: eng_failed};

    smbh_status u_sts (
        .clk      (clk),
        .rst      (rst),
        .clr_en   (wr_acc && (rsel == REG_STS)),
        .clr_mask (bus_wdata),
        .go       (go_req),
        .evt      (evt),
        .stat     (stat_q)
    );

    smbh_blkbuf #(.DEPTH(BLK_DEPTH), .DW(8)) u_blk (
        .clk        (clk),
        .rst        (rst),
        .host_acc   (bus_sel && (rsel == REG_BLK)),
        .host_we    (bus_wr),
        .host_wdata (bus_wdata),
        .ptr_clr    ((wr_acc && (rsel == REG_STS)) || (rd_acc && (rsel == REG_CTL))),
        .eng_we     (eng_blk_we),
        .eng_idx    (eng_blk_idx),
        .eng_wdata  (eng_blk_wdata),
        .host_rdata (blk_rdata),
        .eng_rdata  (eng_blk_rdata),
        .ptr        (blk_ptr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q   <= 8'h00;
            cmd_q   <= 8'h00;
            adr_q   <= 8'h00;
            d0_q    <= 8'h00;
            d1_q    <= 8'h00;
            start_q <= 1'b0;
        end else begin
            start_q <= go_req;
            if (wr_acc) begin
                case (rsel)
                    REG_CTL: ctl_q <= bus_wdata;
                    REG_CMD: cmd_q <= bus_wdata;
                    REG_ADR: adr_q <= bus_wdata;
                    default: ;
                endcase
            end
            if (eng_ld0) begin
                d0_q <= eng_ret0;
            end else if (wr_acc && rsel == REG_D0) begin
                d0_q <= bus_wdata;
            end
            if (eng_ld1) begin
                d1_q <= eng_ret1;
            end else if (wr_acc && rsel == REG_D1) begin
                d1_q <= bus_wdata;
            end
        end
    end

    always_comb begin
        bus_rdata = 8'h00;
        if (rd_acc) begin
            case (rsel)
                REG_STS: bus_rdata = stat_q;
                REG_CTL: bus_rdata = ctl_q & CTL_RD_MASK;
                REG_CMD: bus_rdata = cmd_q;
                REG_ADR: bus_rdata = adr_q;
                REG_D0:  bus_rdata = d0_q;
                REG_D1:  bus_rdata = d1_q;
                REG_BLK: bus_rdata = blk_rdata;
                default: bus_rdata = 8'h00;
            endcase
        end
    end

    assign irq        = stat_q[SB_INTR];
    assign eng_start  = start_q;
    assign eng_proto  = ctl_q[4:2];
    assign eng_slave  = adr_q[7:1];
    assign eng_dir_rd = adr_q[0];
    assign eng_cmd    = cmd_q;
    assign eng_wd0    = d0_q;
    assign eng_wd1    = d1_q;
endmodule

// File: rtl/smbh_regbank_chk.sv
module smbh_regbank_chk #(
    parameter int ADDR_W    = 4,
    parameter int BLK_DEPTH = 32,
    localparam int PTR_W    = $clog2(BLK_DEPTH)
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              irq,
    input logic              eng_start,
    input logic              eng_done,
    input logic              eng_dev_err,
    input logic              eng_bus_err,
    input logic              eng_failed,
    input logic [7:0]        stat_q,
    input logic [PTR_W-1:0]  blk_ptr
);
    localparam logic [PTR_W-1:0] TOP = PTR_W'(BLK_DEPTH - 1);

    logic any_evt;
    logic sts_wr;
    logic ctl_wr_go;
    logic ctl_rd;
    logic blk_acc;
    logic mapped;

    assign any_evt   = eng_done || eng_dev_err || eng_bus_err || eng_failed;
    assign sts_wr    = bus_sel && bus_wr && bus_addr == ADDR_W'(0);
    assign ctl_wr_go = bus_sel && bus_wr && bus_addr == ADDR_W'(2) && bus_wdata[6];
    assign ctl_rd    = bus_sel && !bus_wr && bus_addr == ADDR_W'(2);
    assign blk_acc   = bus_sel && bus_addr == ADDR_W'(7);
    assign mapped    = (bus_addr < ADDR_W'(8)) && (bus_addr != ADDR_W'(1));

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && !mapped) |-> bus_rdata == 8'h00); // R1
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (sts_wr && !any_evt) |=> (stat_q & $past(bus_wdata)) == 8'h00); // R3
    AST_W1C_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (sts_wr && !any_evt) |=> (stat_q & ~$past(bus_wdata)) == ($past(stat_q) & ~$past(bus_wdata))); // R3
    AST_STS_WR_PTR: assert property (@(posedge clk) disable iff (rst)
        sts_wr |=> blk_ptr == '0); // R4
    AST_GO_BUSY: assert property (@(posedge clk) disable iff (rst)
        ctl_wr_go |=> (eng_start && stat_q[0])); // R5
    AST_GO_SINGLE: assert property (@(posedge clk) disable iff (rst)
        !ctl_wr_go |=> !eng_start); // R5
    AST_CTL_RD_MASK: assert property (@(posedge clk) disable iff (rst)
        ctl_rd |-> bus_rdata[7:5] == 3'b000); // R6
    AST_CTL_RD_PTR: assert property (@(posedge clk) disable iff (rst)
        ctl_rd |=> blk_ptr == '0); // R6
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        blk_acc |=> blk_ptr == (($past(blk_ptr) == TOP) ? '0 : $past(blk_ptr) + 1'b1)); // R7
    AST_DONE_SETS: assert property (@(posedge clk) disable iff (rst)
        eng_done |=> (stat_q[7] && stat_q[1] && !stat_q[0])); // R9
    AST_DEVERR_SETS: assert property (@(posedge clk) disable iff (rst)
        eng_dev_err |=> stat_q[2]); // R9
    AST_IRQ_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        eng_done |=> irq); // R10
endmodule

bind smbh_regbank smbh_regbank_chk #(.ADDR_W(ADDR_W), .BLK_DEPTH(BLK_DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .irq         (irq),
    .eng_start   (eng_start),
    .eng_done    (eng_done),
    .eng_dev_err (eng_dev_err),
    .eng_bus_err (eng_bus_err),
    .eng_failed  (eng_failed),
    .stat_q      (stat_q),
    .blk_ptr     (blk_ptr)
);

// File: tb/smbh_regbank_test.sv
`timescale 1ns/1ps
module smbh_regbank_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [3:0] bus_addr = 4'h0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq, eng_start, eng_dir_rd;
    logic [2:0] eng_proto;
    logic [6:0] eng_slave;
    logic [7:0] eng_cmd, eng_wd0, eng_wd1, eng_blk_rdata;
    logic       eng_done = 0, eng_dev_err = 0, eng_bus_err = 0, eng_failed = 0;
    logic       eng_ld0 = 0, eng_ld1 = 0, eng_blk_we = 0;
    logic [7:0] eng_ret0 = 0, eng_ret1 = 0, eng_blk_wdata = 0;
    logic [4:0] eng_blk_idx = 0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    smbh_regbank uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .eng_start(eng_start), .eng_proto(eng_proto),
        .eng_slave(eng_slave), .eng_dir_rd(eng_dir_rd), .eng_cmd(eng_cmd),
        .eng_wd0(eng_wd0), .eng_wd1(eng_wd1), .eng_done(eng_done),
        .eng_dev_err(eng_dev_err), .eng_bus_err(eng_bus_err),
        .eng_failed(eng_failed), .eng_ld0(eng_ld0), .eng_ld1(eng_ld1),
        .eng_ret0(eng_ret0), .eng_ret1(eng_ret1), .eng_blk_we(eng_blk_we),
        .eng_blk_idx(eng_blk_idx), .eng_blk_wdata(eng_blk_wdata),
        .eng_blk_rdata(eng_blk_rdata)
    );

    // {write, offset[3:0], wdata[7:0], expected read[7:0]}
    localparam int NV = 15;
    localparam logic [20:0] VEC [NV] = '{
        {1'b1, 4'h2, 8'h95, 8'h00}, {1'b0, 4'h2, 8'h00, 8'h15},
        {1'b1, 4'h3, 8'h3C, 8'h00}, {1'b0, 4'h3, 8'h00, 8'h3C},
        {1'b1, 4'h4, 8'hA7, 8'h00}, {1'b0, 4'h4, 8'h00, 8'hA7},
        {1'b1, 4'h5, 8'h11, 8'h00}, {1'b0, 4'h5, 8'h00, 8'h11},
        {1'b1, 4'h6, 8'h22, 8'h00}, {1'b0, 4'h6, 8'h00, 8'h22},
        {1'b1, 4'h1, 8'hFF, 8'h00}, {1'b0, 4'h1, 8'h00, 8'h00},
        {1'b0, 4'h9, 8'h00, 8'h00}, {1'b1, 4'hF, 8'h55, 8'h00},
        {1'b0, 4'h0, 8'h00, 8'h00}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bwr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic brd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic epulse(input logic dn, input logic de, input logic be, input logic fl);
        @(negedge clk);
        eng_done = dn; eng_dev_err = de; eng_bus_err = be; eng_failed = fl;
        @(posedge clk);
        @(negedge clk);
        eng_done = 0; eng_dev_err = 0; eng_bus_err = 0; eng_failed = 0;
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;

        brd(4'h0, v); chk("R12 status after reset", v, 8'h00);
        chk("R10 irq after reset", {7'd0, irq}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][20]) begin
                bwr(VEC[i][19:16], VEC[i][15:8]);
            end else begin
                brd(VEC[i][19:16], v);
                chk($sformatf("R1 table entry %0d", i), v, VEC[i][7:0]);
            end
        end
        chk("R8 proto field", {5'd0, eng_proto}, 8'h05);
        chk("R8 slave field", {1'b0, eng_slave}, 8'h53);
        chk("R8 direction", {7'd0, eng_dir_rd}, 8'h01);

        // start bit
        bwr(4'h2, 8'h48);
        chk("R5 start pulse", {7'd0, eng_start}, 8'h01);
        chk("R8 proto after start", {5'd0, eng_proto}, 8'h02);
        @(posedge clk); #1;
        chk("R5 start single cycle", {7'd0, eng_start}, 8'h00);
        brd(4'h0, v); chk("R5 busy set (R2 bit0)", v, 8'h01);

        // completion
        epulse(1, 0, 0, 0);
        brd(4'h0, v); chk("R9 done sets bits 7,1 clears busy", v, 8'h82);
        chk("R10 irq high", {7'd0, irq}, 8'h01);
        bwr(4'h0, 8'h02);
        brd(4'h0, v); chk("R3 clear interrupt only", v, 8'h80);
        chk("R10 irq low", {7'd0, irq}, 8'h00);
        bwr(4'h0, 8'h00);
        brd(4'h0, v); chk("R3 zero write keeps bits", v, 8'h80);
        bwr(4'h0, 8'hFF);
        brd(4'h0, v); chk("R3 clear all", v, 8'h00);

        // set beats clear in the same cycle
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = 4'h0; bus_wdata = 8'hFF; eng_done = 1;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; eng_done = 0;
        brd(4'h0, v); chk("R9 set wins over clear", v, 8'h82);
        bwr(4'h0, 8'hFF);

        // error flags
        epulse(0, 1, 1, 1);
        brd(4'h0, v); chk("R9 error bits 2,3,4", v, 8'h1C);
        bwr(4'h0, 8'hFF);

        // block buffer pointer
        bwr(4'h0, 8'h00);
        bwr(4'h7, 8'hA0); bwr(4'h7, 8'hA1); bwr(4'h7, 8'hA2);
        bwr(4'h0, 8'h00);
        brd(4'h7, v); chk("R4 pointer reset by status write", v, 8'hA0);
        brd(4'h7, v); chk("R7 increment", v, 8'hA1);
        brd(4'h7, v); chk("R7 increment again", v, 8'hA2);
        brd(4'h2, v);
        brd(4'h7, v); chk("R6 control read resets pointer", v, 8'hA0);

        // wrap after 32 entries
        bwr(4'h0, 8'h00);
        for (int i = 0; i < 33; i++) bwr(4'h7, 8'(i));
        bwr(4'h0, 8'h00);
        brd(4'h7, v); chk("R7 wrap overwrote entry 0", v, 8'h20);
        brd(4'h7, v); chk("R7 entry 1 after wrap", v, 8'h01);

        // engine side
        @(negedge clk); eng_blk_idx = 5'd1; #1;
        chk("R11 engine buffer read", eng_blk_rdata, 8'h01);
        @(negedge clk); eng_blk_we = 1; eng_blk_idx = 5'd5; eng_blk_wdata = 8'h77;
        @(posedge clk); @(negedge clk); eng_blk_we = 0;
        bwr(4'h0, 8'h00);
        for (int i = 0; i < 6; i++) brd(4'h7, v);
        chk("R11 engine buffer write", v, 8'h77);
        @(negedge clk); eng_ret0 = 8'h5A; eng_ret1 = 8'hC3; eng_ld0 = 1; eng_ld1 = 1;
        bus_sel = 1; bus_wr = 1; bus_addr = 4'h5; bus_wdata = 8'h99;
        @(posedge clk); @(negedge clk); eng_ld0 = 0; eng_ld1 = 0; bus_sel = 0; bus_wr = 0;
        brd(4'h5, v); chk("R11 data-low load wins", v, 8'h5A);
        brd(4'h6, v); chk("R11 data-high load", v, 8'hC3);

        // reset mid-run
        epulse(1, 0, 0, 0);
        @(negedge clk) rst = 1;
        @(negedge clk) rst = 0;
        brd(4'h0, v); chk("R12 status cleared", v, 8'h00);
        brd(4'h2, v); chk("R12 control cleared", v, 8'h00);
        brd(4'h5, v); chk("R12 data-low cleared", v, 8'h00);
        brd(4'h7, v); chk("R12 buffer entry cleared", v, 8'h00);
        chk("R12 irq cleared", {7'd0, irq}, 8'h00);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule